// File: doc/BRIEF.md
# Masked Eight-Line Interrupt Collector

This block gathers up to eight interrupt request lines into one request register and drives a single combined interrupt line toward a host. Side-band logic posts and removes request bits as whole vectors. Software works through a byte-wide register port. Through that port it programs which lines may interrupt, reads the pending requests and retires one request at a time with an end-of-interrupt command that names the line number. The host interrupt is high exactly while some pending request is also enabled. It is recomputed on every event that can change that answer, including a mask write.

The enable state is kept in positive form, so a set bit lets a line through. Software writes and reads the mask in negative form, where a 0 bit means the line is unmasked, and each write is complemented on the way in. A second, subordinate controller is present only as a plain storage byte for its mask and a status byte that always reads zero. Neither of them ever affects the interrupt line. The request register can also be fetched with a 64-bit access.

Register addresses on `addr`: 0 is request (read) and end-of-interrupt command (write), 1 is the primary mask, 2 is the secondary status, and 3 is the secondary mask.

Top module: `irqc_top`

## Requirements
- R1: A write to address 1 stores the bitwise complement of `wdata` as the enable set, so a 0 in bit n of the written byte enables line n.
- R2: A read of address 1 returns the byte most recently written there. After reset it reads 0xFF.
- R3: `irq_out` is high exactly when (request AND enable) is non-zero. It follows any mask write, post, drop or end-of-interrupt on the first rising clock edge after that event, and it changes at no other time.
- R4: A write to address 0 clears the request bit whose number is `wdata[3:0]`. Bits 7:4 of the data are ignored, and numbers 8 to 15 clear nothing.
- R5: While `post_en` is high, `post_vec` is ORed into the request register at the next clock edge.
- R6: While `drop_en` is high, the bits set in `drop_vec` are cleared from the request register. In a single cycle the new request value is ((request OR post) AND NOT drop) AND NOT eoi-bit, so a drop or an end-of-interrupt overrides a post of the same bit.
- R7: A read of address 2 returns 0x00 at all times. Writes to address 2 change no state.
- R8: Address 3 stores the written byte unchanged and reads it back. Writing it has no effect on the request register or on `irq_out`. Its reset value is 0x00.
- R9: With `rd_wide` high, a read of address 0 returns the request byte zero-extended to 64 bits, and a read of any other address returns 0. Byte reads (`rd_wide` low) return the register in bits 7:0 with bits 63:8 zero.
- R10: While `rst_n` is low, the request register is zero, all lines are disabled (address 1 reads 0xFF), address 3 reads 0x00 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for the address on `addr` |
| addr | input | 2 | Register address, used for both write and read |
| wdata | input | 8 | Register write data |
| rd_wide | input | 1 | Selects a 64-bit read instead of a byte read |
| rd_data | output | 64 | Combinational read data for `addr` |
| post_en | input | 1 | Side-band request: OR `post_vec` into requests |
| post_vec | input | 8 | Request bits to raise |
| drop_en | input | 1 | Side-band request: remove `drop_vec` from requests |
| drop_vec | input | 8 | Request bits to clear |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
Every register update and `irq_out` itself land on the first rising edge after the cycle in which the stimulus is presented. `rd_data` is a pure function of the current `addr`, `rd_wide` and register state, so it shows no latency of its own. The bench drives each stimulus on a falling edge and withdraws it on the next falling edge. It then checks both `irq_out` and the read-back a short delay later, which places the check after exactly one rising edge. Reset values are checked while `rst_n` is still low, because the reset is asynchronous and takes effect with no clock edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned ADDR_W = 2;
  localparam int unsigned RD_W   = 64;

  typedef enum logic [ADDR_W-1:0] {
    A_REQ   = 2'd0,
    A_PMASK = 2'd1,
    A_SSTAT = 2'd2,
    A_SMASK = 2'd3
  } irqc_addr_e;

endpackage

// File: rtl/irqc_req_reg.sv
module irqc_req_reg #(
  parameter int W     = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_en,
  input  logic [W-1:0]     post_vec,
  input  logic             drop_en,
  input  logic [W-1:0]     drop_vec,
  input  logic             eoi_en,
  input  logic [IDX_W-1:0] eoi_idx,
  output logic [W-1:0]     req_q,
  output logic [W-1:0]     req_d
);

  // Line number to single-bit mask; numbers beyond the line count map to zero.
  function automatic logic [W-1:0] idx_to_bit(input logic [IDX_W-1:0] idx);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (idx == IDX_W'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction

  // Set first, then clear: clears win over a same-cycle set.
  function automatic logic [W-1:0] next_req(input logic [W-1:0] cur,
                                            input logic [W-1:0] set_m,
                                            input logic [W-1:0] clr_m,
                                            input logic [W-1:0] eoi_m);
    return ((cur | set_m) & ~clr_m) & ~eoi_m;
  endfunction

  logic [W-1:0] set_m, clr_m, eoi_m;

  assign set_m = {W{post_en}} & post_vec;
  assign clr_m = {W{drop_en}} & drop_vec;
  assign eoi_m = {W{eoi_en}}  & idx_to_bit(eoi_idx);
  assign req_d = next_req(req_q, set_m, clr_m, eoi_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  a_r5_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (post_en && !drop_en && !eoi_en) |=> ((req_q & $past(post_vec)) == $past(post_vec)));

  a_r6_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |=> ((req_q & $past(drop_vec)) == '0));

  a_r4_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_en |=> ((req_q & $past(idx_to_bit(eoi_idx))) == '0));

  a_r4_eoi_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_en && !post_en && !drop_en && (eoi_idx >= W)) |=> $stable(req_q));

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] en_d,
  output logic [W-1:0] rd_val
);

  generate
    if (INVERT) begin : g_inv
      // Held as positive enables; software sees the negative form.
      assign en_d   = wr_en ? ~wdata : en_q;
      assign rd_val = ~en_q;

      a_r1_store_complement: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == ~$past(wdata)));
    end else begin : g_plain
      assign en_d   = wr_en ? wdata : en_q;
      assign rd_val = en_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_val == $past(wdata)));

endmodule

// File: rtl/irqc_flag.sv
module irqc_flag #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_d,
  input  logic [W-1:0] en_d,
  output logic         irq_q,
  output logic         raise_evt,
  output logic         fall_evt
);

  function automatic logic any_enabled(input logic [W-1:0] r, input logic [W-1:0] e);
    return |(r & e);
  endfunction

  logic want;

  assign want      = any_enabled(req_d, en_d);
  assign raise_evt = want & ~irq_q;
  assign fall_evt  = ~want & irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (raise_evt) irq_q <= 1'b1;
    else if (fall_evt)  irq_q <= 1'b0;
  end

  a_r3_raise: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> irq_q);

  a_r3_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !irq_q);

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise_evt && !fall_evt) |=> $stable(irq_q));

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({raise_evt, fall_evt}));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int W         = 8,
  parameter int EOI_IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              rd_wide,
  output logic [RD_W-1:0]   rd_data,
  input  logic              post_en,
  input  logic [W-1:0]      post_vec,
  input  logic              drop_en,
  input  logic [W-1:0]      drop_vec,
  output logic              irq_out
);

  localparam int PAD_W = RD_W - W;

  irqc_addr_e  sel;
  logic        wr_eoi, wr_pmask, wr_smask;
  logic [W-1:0] req_q, req_d;
  logic [W-1:0] p_en_q, p_en_d, p_rd;
  logic [W-1:0] s_en_q, s_en_d, s_rd;
  logic        raise_evt, fall_evt;
  logic [W-1:0] rd_byte;

  assign sel      = irqc_addr_e'(addr);
  assign wr_eoi   = wr_en && (sel == A_REQ);
  assign wr_pmask = wr_en && (sel == A_PMASK);
  assign wr_smask = wr_en && (sel == A_SMASK);

  irqc_req_reg #(.W(W), .IDX_W(EOI_IDX_W)) i_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_en  (post_en),
    .post_vec (post_vec),
    .drop_en  (drop_en),
    .drop_vec (drop_vec),
    .eoi_en   (wr_eoi),
    .eoi_idx  (wdata[EOI_IDX_W-1:0]),
    .req_q    (req_q),
    .req_d    (req_d)
  );

  irqc_mask_reg #(.W(W), .INVERT(1'b1)) i_pmask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_pmask),
    .wdata  (wdata),
    .en_q   (p_en_q),
    .en_d   (p_en_d),
    .rd_val (p_rd)
  );

  irqc_mask_reg #(.W(W), .INVERT(1'b0)) i_smask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_smask),
    .wdata  (wdata),
    .en_q   (s_en_q),
    .en_d   (s_en_d),
    .rd_val (s_rd)
  );

  irqc_flag #(.W(W)) i_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_d     (req_d),
    .en_d      (p_en_d),
    .irq_q     (irq_out),
    .raise_evt (raise_evt),
    .fall_evt  (fall_evt)
  );

  always_comb begin
    unique case (sel)
      A_REQ:   rd_byte = req_q;
      A_PMASK: rd_byte = p_rd;
      A_SSTAT: rd_byte = '0;
      A_SMASK: rd_byte = s_rd;
      default: rd_byte = '0;
    endcase
  end

  always_comb begin
    if (rd_wide && (sel != A_REQ)) rd_data = '0;
    else                           rd_data = {{PAD_W{1'b0}}, rd_byte};
  end

  a_r3_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|(req_q & p_en_q)));

  a_r3_edge_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(raise_evt));

  a_r8_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_smask |-> (s_en_d == wdata));

  a_r8_sec_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_smask && !post_en && !drop_en) |=> ($stable(irq_out) && $stable(req_q)));

  a_r8_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_smask |=> $stable(s_en_q));

  a_r7_sstat_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == A_SSTAT) && !post_en && !drop_en)
      |=> ($stable(req_q) && $stable(p_en_q) && $stable(s_en_q)));

  a_r9_wide_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RD_W-1:W] == '0);

endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic        rd_wide;
  logic [63:0] rd_data;
  logic        post_en;
  logic [7:0]  post_vec;
  logic        drop_en;
  logic [7:0]  drop_vec;
  logic        irq_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_wide(rd_wide), .rd_data(rd_data), .post_en(post_en), .post_vec(post_vec),
    .drop_en(drop_en), .drop_vec(drop_vec), .irq_out(irq_out)
  );

  localparam logic [1:0] K_WR = 2'd0, K_POST = 2'd1, K_DROP = 2'd2;

  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] a;
    logic [7:0] d;
    logic       exp_irq;
    logic [7:0] exp_req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{K_POST, 2'd0, 8'h05, 1'b0, 8'h05},  // R5 post while all masked
    '{K_WR,   2'd1, 8'hFE, 1'b1, 8'h05},  // R1 R3 unmask line 0
    '{K_WR,   2'd1, 8'hFF, 1'b0, 8'h05},  // R3 mask all
    '{K_WR,   2'd1, 8'hFB, 1'b1, 8'h05},  // R1 unmask line 2
    '{K_WR,   2'd0, 8'h02, 1'b0, 8'h01},  // R4 retire line 2
    '{K_WR,   2'd0, 8'h0A, 1'b0, 8'h01},  // R4 number 10 clears nothing
    '{K_WR,   2'd1, 8'h00, 1'b1, 8'h01},  // R1 unmask all
    '{K_DROP, 2'd0, 8'h01, 1'b0, 8'h00},  // R6 drop last request
    '{K_POST, 2'd0, 8'h80, 1'b1, 8'h80},  // R5 post line 7
    '{K_WR,   2'd3, 8'h00, 1'b1, 8'h80},  // R8 secondary mask inert
    '{K_WR,   2'd0, 8'h17, 1'b0, 8'h00},  // R4 upper nibble ignored
    '{K_POST, 2'd0, 8'h06, 1'b1, 8'h06},  // R5
    '{K_DROP, 2'd0, 8'h04, 1'b1, 8'h02},  // R6 enabled request remains
    '{K_DROP, 2'd0, 8'h02, 1'b0, 8'h00}   // R6 R3 last one gone
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; addr = 2'd0; wdata = 8'h00; rd_wide = 1'b0;
    post_en = 1'b0; post_vec = 8'h00; drop_en = 1'b0; drop_vec = 8'h00;
  endtask

  // One stimulus cycle; returns just after the capturing rising edge has settled.
  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     input logic pe, input logic [7:0] pv,
                     input logic de, input logic [7:0] dv);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; post_en = pe; post_vec = pv;
    drop_en = de; drop_vec = dv;
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic rd(input logic [1:0] a, input logic wide, output logic [63:0] v);
    addr = a; rd_wide = wide;
    #1;
    v = rd_data;
    addr = 2'd0; rd_wide = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    check("R10 irq", {63'd0, irq_out}, 64'd0);
    rd(2'd0, 1'b0, v); check("R10 req", v, 64'h00);
    rd(2'd1, 1'b0, v); check("R10 pmask", v, 64'hFF);
    rd(2'd3, 1'b0, v); check("R10 smask", v, 64'h00);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      cyc(VEC[k].kind == K_WR, VEC[k].a, VEC[k].d,
          VEC[k].kind == K_POST, VEC[k].d,
          VEC[k].kind == K_DROP, VEC[k].d);
      check($sformatf("R3 vec%0d irq", k), {63'd0, irq_out}, {63'd0, VEC[k].exp_irq});
      rd(2'd0, 1'b0, v);
      check($sformatf("R4/R5/R6 vec%0d req", k), v, {56'd0, VEC[k].exp_req});
    end

    // R2 readback of last mask write and of a fresh one
    rd(2'd1, 1'b0, v); check("R2 pmask last", v, 64'h00);
    cyc(1'b1, 2'd1, 8'h5A, 1'b0, 8'h00, 1'b0, 8'h00);
    rd(2'd1, 1'b0, v); check("R2 pmask 5A", v, 64'h5A);
    // R1 enables are ~5A = A5, line 5 enabled
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'h20, 1'b0, 8'h00);
    check("R1 line5 enabled", {63'd0, irq_out}, 64'd1);
    cyc(1'b1, 2'd1, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R3 masked off", {63'd0, irq_out}, 64'd0);

    // R9 wide and byte reads
    rd(2'd0, 1'b1, v); check("R9 wide req", v, 64'h20);
    rd(2'd1, 1'b1, v); check("R9 wide other", v, 64'h0);
    rd(2'd1, 1'b0, v); check("R9 byte pmask", v, 64'hFF);

    // R7 secondary status
    rd(2'd2, 1'b0, v); check("R7 sstat", v, 64'h00);
    cyc(1'b1, 2'd2, 8'h77, 1'b0, 8'h00, 1'b0, 8'h00);
    rd(2'd2, 1'b0, v); check("R7 sstat after write", v, 64'h00);
    rd(2'd0, 1'b0, v); check("R7 req untouched", v, 64'h20);
    rd(2'd1, 1'b0, v); check("R7 pmask untouched", v, 64'hFF);

    // R8 secondary mask storage with interrupt asserted
    cyc(1'b1, 2'd1, 8'hDF, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R3 line5 unmasked", {63'd0, irq_out}, 64'd1);
    cyc(1'b1, 2'd3, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R8 irq kept", {63'd0, irq_out}, 64'd1);
    rd(2'd3, 1'b0, v); check("R8 smask FF", v, 64'hFF);
    cyc(1'b1, 2'd3, 8'h3C, 1'b0, 8'h00, 1'b0, 8'h00);
    rd(2'd3, 1'b0, v); check("R8 smask 3C", v, 64'h3C);
    rd(2'd0, 1'b0, v); check("R8 req untouched", v, 64'h20);

    // R6 same-cycle ordering
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'h03, 1'b1, 8'h01);
    rd(2'd0, 1'b0, v); check("R6 post+drop", v, 64'h22);
    cyc(1'b1, 2'd0, 8'h06, 1'b1, 8'h40, 1'b0, 8'h00);
    rd(2'd0, 1'b0, v); check("R6 post+eoi", v, 64'h22);
    check("R3 still high", {63'd0, irq_out}, 64'd1);

    // R10 reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 irq mid", {63'd0, irq_out}, 64'd0);
    rd(2'd0, 1'b0, v); check("R10 req mid", v, 64'h00);
    rd(2'd1, 1'b0, v); check("R10 pmask mid", v, 64'hFF);
    rd(2'd3, 1'b0, v); check("R10 smask mid", v, 64'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule